// File: doc/BRIEF.md
# Strobe Phase Window Calibration Sweeper

This block calibrates the output-strobe delay of a parallel interface in hardware, so that no embedded processor has to run the loop. When `start` is pulsed, the block first reads the current strobe delay from a delay control register. It then sweeps delay codes from a minimum to a maximum in fixed steps. For each code it writes the code to the delay register and writes the apply register. It then starts a loopback data test and waits for the test engine's result.

The block looks for the first contiguous run of passing codes. The sweep stops at the first failing code that follows a pass. After the sweep the block programs the centre of the window, or the original delay if no code passed. It then reports the window start, end, centre and width, together with a pass flag and a done flag. Per-data-bit delays are never touched. The delay register and the apply register are reached through a simple register master port with a wait-request handshake. The test engine is reached through a start/done pulse pair.

Top module: `strobe_cal_sweeper`

## Requirements
- R1: After reset, `cal_busy`, `cal_done`, `cal_pass`, `test_start`, `reg_write` and `reg_read` are low, and all window outputs are zero.
- R2: A `start` pulse while idle raises `cal_busy` and clears `cal_done`. The first register access is a read of address `DELAY_REG_ADDR` (default 0x10). A `start` while busy has no effect on the access sequence.
- R3: For each code from `CODE_MIN` upward in steps of `CODE_STEP`, never above `CODE_MAX`, the block writes the code (zero-extended) to `DELAY_REG_ADDR`, then writes the value 1 to `APPLY_REG_ADDR` (default 0x11), then gives exactly one single-cycle `test_start` pulse.
- R4: While `reg_wait` is high during an access, `reg_write`/`reg_read`, `reg_addr` and `reg_wdata` stay unchanged. A read completes only when `reg_rvalid` is seen.
- R5: `test_pass` is taken only in a cycle where `test_done` is high while the block waits for a test. A `test_done` pulse at any other time is ignored.
- R6: `win_start` is the first passing code and `win_end` is the last passing code of the first contiguous run. The sweep ends after the first failing code that follows a pass, or after the last code in range.
- R7: `win_width` = end − start + 1 and `win_center` = start + floor(width/2). After the sweep the centre is written to `DELAY_REG_ADDR` and then 1 to `APPLY_REG_ADDR`.
- R8: If no code passes, the originally read delay is written back and applied, `cal_pass` is 0, all window outputs are 0, and `cal_done` is still raised.
- R9: `cal_done` rises, and `cal_busy` falls, once the final apply write is accepted. `cal_done` stays high with the results until the next `start`. `cal_done` and `cal_busy` are never high together.
- R10: `reg_write` and `reg_read` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a calibration |
| reg_addr | output | ADDR_W | Register access address |
| reg_wdata | output | DATA_W | Register write data |
| reg_write | output | 1 | Write strobe, held until accepted |
| reg_read | output | 1 | Read strobe, held until accepted |
| reg_wait | input | 1 | Slave wait-request; access is accepted in a cycle where it is low |
| reg_rdata | input | DATA_W | Read data |
| reg_rvalid | input | 1 | Read data valid |
| test_start | output | 1 | One-cycle request to run a loopback test |
| test_done | input | 1 | One-cycle test completion |
| test_pass | input | 1 | Test result, valid with `test_done` |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Calibration finished, results valid |
| cal_pass | output | 1 | A passing window was found |
| win_start | output | CODE_W | First passing code |
| win_end | output | CODE_W | Last passing code |
| win_center | output | CODE_W | Programmed centre code |
| win_width | output | CODE_W+1 | Window width in code units |

## Verification
The assertions check, on every cycle, the rules that can be seen locally:
- the access strobes, address and data are held while wait-request is high, and the two strobes are exclusive;
- `test_start` is a single-cycle pulse;
- the window tracker's closed state is sticky, and its end code is never below its start code;
- the reported centre lies inside the window, and a failed calibration reports zero width;
- done and busy never overlap.

Only the bench scenarios can show the rest:
- the ordering and values of the whole access sequence under random wait states;
- the choice of the first window when a second one exists;
- the early stop, and restoring the original delay;
- ignoring stray test completions and a repeated `start`.

// File: rtl/strobe_cal_pkg.sv
package strobe_cal_pkg;

  typedef enum logic [2:0] {
    SW_IDLE,
    SW_RD_ORIG,
    SW_WR_CODE,
    SW_UPD_CODE,
    SW_TEST,
    SW_PICK,
    SW_WR_FINAL,
    SW_UPD_FINAL
  } sweep_state_e;

  typedef enum logic [1:0] {
    BM_IDLE,
    BM_CMD,
    BM_RDATA
  } bus_state_e;

endpackage

// File: rtl/scm_bus_master.sv
module scm_bus_master
  import strobe_cal_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] ack_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_write,
  output logic              bus_read,
  input  logic              bus_wait,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rvalid
);

  bus_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= BM_IDLE;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_write <= 1'b0;
      bus_read  <= 1'b0;
      ack       <= 1'b0;
      ack_rdata <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        BM_IDLE: begin
          if (req) begin
            bus_addr  <= req_addr;
            bus_wdata <= req_write ? req_wdata : '0;
            bus_write <= req_write;
            bus_read  <= ~req_write;
            st        <= BM_CMD;
          end
        end
        BM_CMD: begin
          if (!bus_wait) begin
            bus_write <= 1'b0;
            bus_read  <= 1'b0;
            if (bus_write) begin
              ack <= 1'b1;
              st  <= BM_IDLE;
            end else begin
              st <= BM_RDATA;
            end
          end
        end
        BM_RDATA: begin
          if (bus_rvalid) begin
            ack_rdata <= bus_rdata;
            ack       <= 1'b1;
            st        <= BM_IDLE;
          end
        end
        default: st <= BM_IDLE;
      endcase
    end
  end

  // R4: the access is held steady while the slave stalls it
  p_hold_on_wait_r4: assert property (@(posedge clk) disable iff (rst)
    ((bus_write || bus_read) && bus_wait) |=>
      (bus_write == $past(bus_write)) && (bus_read == $past(bus_read)) &&
      $stable(bus_addr) && $stable(bus_wdata));

  // R10: the read and write strobes never overlap
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_write && bus_read));

  p_ack_single_r4: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

endmodule

// File: rtl/scm_window_tracker.sv
module scm_window_tracker #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic [CODE_W-1:0] code,
  input  logic              pass,
  output logic              found,
  output logic              closed,
  output logic [CODE_W-1:0] start_code,
  output logic [CODE_W-1:0] end_code,
  output logic [CODE_W:0]   width,
  output logic [CODE_W-1:0] center
);

  localparam int WW = CODE_W + 1;

  logic [WW-1:0] span;
  logic [WW-1:0] mid;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      found      <= 1'b0;
      closed     <= 1'b0;
      start_code <= '0;
      end_code   <= '0;
    end else if (sample && !closed) begin
      if (pass) begin
        if (!found) begin
          found      <= 1'b1;
          start_code <= code;
        end
        end_code <= code;
      end else if (found) begin
        closed <= 1'b1;
      end
    end
  end

  always_comb begin
    span   = {1'b0, end_code} - {1'b0, start_code} + WW'(1);
    width  = found ? span : '0;
    mid    = {1'b0, start_code} + {1'b0, width[WW-1:1]};
    center = mid[CODE_W-1:0];
  end

  // R6: once the first window has closed it stays closed until cleared
  p_closed_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (closed && !clear) |=> closed);

  // R6: the window end never precedes its start
  p_end_after_start_r6: assert property (@(posedge clk) disable iff (rst)
    found |-> (end_code >= start_code));

  p_closed_needs_found_r6: assert property (@(posedge clk) disable iff (rst)
    closed |-> found);

endmodule

// File: rtl/strobe_cal_sweeper.sv
module strobe_cal_sweeper
  import strobe_cal_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int CODE_W    = 8,
  parameter int CODE_MIN  = 4,
  parameter int CODE_MAX  = 60,
  parameter int CODE_STEP = 2,
  parameter logic [ADDR_W-1:0] DELAY_REG_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] APPLY_REG_ADDR = 'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_write,
  output logic              reg_read,
  input  logic              reg_wait,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_rvalid,
  output logic              test_start,
  input  logic              test_done,
  input  logic              test_pass,
  output logic              cal_busy,
  output logic              cal_done,
  output logic              cal_pass,
  output logic [CODE_W-1:0] win_start,
  output logic [CODE_W-1:0] win_end,
  output logic [CODE_W-1:0] win_center,
  output logic [CODE_W:0]   win_width
);

  localparam int CW1 = CODE_W + 1;
  localparam logic [CW1-1:0]    MAX_EXT  = CW1'(CODE_MAX);
  localparam logic [CW1-1:0]    STEP_EXT = CW1'(CODE_STEP);
  localparam logic [CODE_W-1:0] MIN_CODE = CODE_W'(CODE_MIN);

  sweep_state_e state;
  logic              pend;
  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] orig_code;
  logic [CODE_W-1:0] fin_code;

  logic              acc_req, acc_write, acc_ack, acc_is;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata, acc_rdata;
  logic [CODE_W-1:0] sel_code;
  logic [DATA_W-1:0] sel_wide;
  logic [CODE_W-1:0] rd_code;
  logic              is_apply;

  logic              test_wait, smp, closing, last_code, trk_clear;
  logic [CW1-1:0]    next_ext;

  logic              trk_found, trk_closed;
  logic [CODE_W-1:0] trk_start, trk_end, trk_center;
  logic [CODE_W:0]   trk_width;

  // width adaptation between code and register data
  generate
    if (DATA_W > CODE_W) begin : g_wide_bus
      assign sel_wide = {{(DATA_W-CODE_W){1'b0}}, sel_code};
      assign rd_code  = acc_rdata[CODE_W-1:0];
    end else begin : g_narrow_bus
      assign sel_wide = sel_code[DATA_W-1:0];
      assign rd_code  = CODE_W'(acc_rdata);
    end
  endgenerate

  always_comb begin
    acc_is    = (state == SW_RD_ORIG) || (state == SW_WR_CODE) ||
                (state == SW_UPD_CODE) || (state == SW_WR_FINAL) ||
                (state == SW_UPD_FINAL);
    acc_req   = acc_is && !pend;
    acc_write = (state != SW_RD_ORIG);
    is_apply  = (state == SW_UPD_CODE) || (state == SW_UPD_FINAL);
    sel_code  = (state == SW_WR_CODE) ? code : fin_code;
    acc_addr  = is_apply ? APPLY_REG_ADDR : DELAY_REG_ADDR;
    acc_wdata = is_apply ? DATA_W'(1) : sel_wide;
    test_wait = (state == SW_TEST) && pend;
    smp       = test_wait && test_done;
    closing   = trk_found && !test_pass;
    next_ext  = {1'b0, code} + STEP_EXT;
    last_code = next_ext > MAX_EXT;
    trk_clear = (state == SW_IDLE) && start;
  end

  scm_bus_master #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .req       (acc_req),
    .req_write (acc_write),
    .req_addr  (acc_addr),
    .req_wdata (acc_wdata),
    .ack       (acc_ack),
    .ack_rdata (acc_rdata),
    .bus_addr  (reg_addr),
    .bus_wdata (reg_wdata),
    .bus_write (reg_write),
    .bus_read  (reg_read),
    .bus_wait  (reg_wait),
    .bus_rdata (reg_rdata),
    .bus_rvalid(reg_rvalid)
  );

  scm_window_tracker #(
    .CODE_W(CODE_W)
  ) u_trk (
    .clk       (clk),
    .rst       (rst),
    .clear     (trk_clear),
    .sample    (smp),
    .code      (code),
    .pass      (test_pass),
    .found     (trk_found),
    .closed    (trk_closed),
    .start_code(trk_start),
    .end_code  (trk_end),
    .width     (trk_width),
    .center    (trk_center)
  );

  // outstanding-request flag shared by bus accesses and tests
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (acc_ack || smp) begin
      pend <= 1'b0;
    end else if (acc_req || ((state == SW_TEST) && !pend)) begin
      pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SW_IDLE;
      code       <= '0;
      orig_code  <= '0;
      fin_code   <= '0;
      test_start <= 1'b0;
      cal_busy   <= 1'b0;
      cal_done   <= 1'b0;
      cal_pass   <= 1'b0;
      win_start  <= '0;
      win_end    <= '0;
      win_center <= '0;
      win_width  <= '0;
    end else begin
      test_start <= 1'b0;
      case (state)
        SW_IDLE: begin
          if (start) begin
            cal_busy <= 1'b1;
            cal_done <= 1'b0;
            state    <= SW_RD_ORIG;
          end
        end
        SW_RD_ORIG: begin
          if (acc_ack) begin
            orig_code <= rd_code;
            code      <= MIN_CODE;
            state     <= SW_WR_CODE;
          end
        end
        SW_WR_CODE: if (acc_ack) state <= SW_UPD_CODE;
        SW_UPD_CODE: if (acc_ack) state <= SW_TEST;
        SW_TEST: begin
          if (!pend) begin
            test_start <= 1'b1;
          end else if (smp) begin
            if (closing || last_code) begin
              state <= SW_PICK;
            end else begin
              code  <= next_ext[CODE_W-1:0];
              state <= SW_WR_CODE;
            end
          end
        end
        SW_PICK: begin
          fin_code <= trk_found ? trk_center : orig_code;
          state    <= SW_WR_FINAL;
        end
        SW_WR_FINAL: if (acc_ack) state <= SW_UPD_FINAL;
        SW_UPD_FINAL: begin
          if (acc_ack) begin
            cal_busy   <= 1'b0;
            cal_done   <= 1'b1;
            cal_pass   <= trk_found;
            win_start  <= trk_found ? trk_start : '0;
            win_end    <= trk_found ? trk_end : '0;
            win_center <= trk_found ? trk_center : '0;
            win_width  <= trk_width;
            state      <= SW_IDLE;
          end
        end
        default: state <= SW_IDLE;
      endcase
    end
  end

  // R3: each test request is a single-cycle pulse
  p_test_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    test_start |=> !test_start);

  // R3: tests only run on codes inside the sweep range
  p_code_range_r3: assert property (@(posedge clk) disable iff (rst)
    test_start |-> (code >= MIN_CODE) && ({1'b0, code} <= MAX_EXT));

  // R7: the reported centre lies in the reported window
  p_center_inside_r7: assert property (@(posedge clk) disable iff (rst)
    (cal_done && cal_pass) |-> (win_center >= win_start) && (win_center <= win_end));

  // R8: a failed calibration reports an empty window
  p_fail_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (cal_done && !cal_pass) |-> (win_width == '0));

  // R9: done and busy are exclusive
  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    !(cal_done && cal_busy));

endmodule

// File: tb/strobe_cal_sweeper_bench.sv
module strobe_cal_sweeper_bench;

  localparam int AW = 8, DW = 16, CW = 8;
  localparam int MINC = 4, MAXC = 60, STEPC = 2;
  localparam logic [AW-1:0] DLY_A = 8'h10;
  localparam logic [AW-1:0] UPD_A = 8'h11;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic reg_write, reg_read, reg_wait, reg_rvalid;
  logic test_start, test_done, test_pass;
  logic cal_busy, cal_done, cal_pass;
  logic [CW-1:0] win_start, win_end, win_center;
  logic [CW:0] win_width;

  always #4 clk = ~clk;

  strobe_cal_sweeper #(
    .ADDR_W(AW), .DATA_W(DW), .CODE_W(CW),
    .CODE_MIN(MINC), .CODE_MAX(MAXC), .CODE_STEP(STEPC),
    .DELAY_REG_ADDR(DLY_A), .APPLY_REG_ADDR(UPD_A)
  ) u_strobe_cal_sweeper (
    .clk(clk), .rst(rst), .start(start),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_write(reg_write),
    .reg_read(reg_read), .reg_wait(reg_wait), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .test_start(test_start), .test_done(test_done),
    .test_pass(test_pass), .cal_busy(cal_busy), .cal_done(cal_done),
    .cal_pass(cal_pass), .win_start(win_start), .win_end(win_end),
    .win_center(win_center), .win_width(win_width)
  );

  int n_chk = 0, n_fail = 0;
  int lo1, hi1, lo2, hi2, init_val;
  int scen_tok = 0, stray_tok = 0;

  logic [AW-1:0] log_addr [256];
  logic [DW-1:0] log_data [256];
  bit            log_wr   [256];
  int n_log, n_tests, mem_dly, applied;

  function automatic bit pass_fn(input int c);
    return (c >= lo1 && c <= hi1) || (c >= lo2 && c <= hi2);
  endfunction

  // register slave and loopback test engine, driven away from the active edge
  int scen_seen = 0, stray_seen = 0, waits = 0, eng_cnt = 0;
  bit in_acc = 0, rd_pend = 0;
  initial begin
    reg_wait = 0; reg_rvalid = 0; reg_rdata = '0; test_done = 0; test_pass = 0;
    n_log = 0; n_tests = 0; mem_dly = 0; applied = 0;
  end
  always @(negedge clk) begin
    if (scen_tok != scen_seen) begin
      scen_seen = scen_tok; mem_dly = init_val; applied = init_val;
      n_log = 0; n_tests = 0;
    end
    reg_rvalid = 0;
    if (rd_pend) begin
      reg_rvalid = 1; reg_rdata = DW'(mem_dly); rd_pend = 0;
    end
    if (reg_write || reg_read) begin
      if (!in_acc) begin in_acc = 1; waits = int'($urandom % 3); end
      if (waits > 0) begin
        reg_wait = 1; waits--;
      end else begin
        reg_wait = 0; in_acc = 0;
        if (n_log < 256) begin
          log_addr[n_log] = reg_addr; log_data[n_log] = reg_wdata; log_wr[n_log] = reg_write;
        end
        n_log++;
        if (reg_write && reg_addr == DLY_A) mem_dly = int'(reg_wdata);
        if (reg_write && reg_addr == UPD_A) applied = mem_dly;
        if (reg_read) rd_pend = 1;
      end
    end else begin
      reg_wait = 0;
    end
    test_done = 0;
    test_pass = 1'($urandom % 2);
    if (stray_tok != stray_seen) begin
      stray_seen = stray_tok; test_done = 1; test_pass = 1;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        test_done = 1; test_pass = pass_fn(applied); n_tests++;
      end
    end else if (test_start) begin
      eng_cnt = 1 + int'($urandom % 4);
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic run_case(input int l1, input int h1, input int l2, input int h2,
                          input int init, input bit stray, input bit restart);
    int ecodes[64];
    int en = 0, es = 0, ee = 0, ew = 0, ec = 0, efin;
    bit ef = 0;
    int bad = 0, t = 0, f;
    lo1 = l1; hi1 = h1; lo2 = l2; hi2 = h2; init_val = init;
    for (int c = MINC; c <= MAXC; c += STEPC) begin
      ecodes[en] = c; en++;
      if (pass_fn(c)) begin
        if (!ef) begin ef = 1; es = c; end
        ee = c;
      end else if (ef) begin
        break;
      end
    end
    if (ef) begin ew = ee - es + 1; ec = es + ew / 2; end
    efin = ef ? ec : init;
    scen_tok++;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(cal_busy && !cal_done, "R2 busy after start", int'(cal_busy), 1);
    if (stray) stray_tok++;
    if (restart) begin
      repeat (40) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (!cal_done && t < 5000) begin @(negedge clk); t++; end
    chk(cal_done && !cal_busy, "R9 done raised, busy low", int'(cal_done), 1);
    chk(!log_wr[0] && log_addr[0] == DLY_A, "R2 first access reads delay", int'(log_addr[0]), int'(DLY_A));
    chk(n_log == 2 * en + 3, "R3 access count", n_log, 2 * en + 3);
    chk(n_tests == en, "R5 tests run", n_tests, en);
    for (int i = 0; i < en && 2 + 2 * i < 256; i++) begin
      if (!log_wr[1+2*i] || log_addr[1+2*i] != DLY_A || int'(log_data[1+2*i]) != ecodes[i]) bad++;
      if (!log_wr[2+2*i] || log_addr[2+2*i] != UPD_A || int'(log_data[2+2*i]) != 1) bad++;
    end
    chk(bad == 0, "R3 R4 sweep write sequence", bad, 0);
    f = 1 + 2 * en;
    if (f + 1 < 256) begin
      chk(log_wr[f] && log_addr[f] == DLY_A && int'(log_data[f]) == efin,
          ef ? "R7 final centre write" : "R8 original delay restored", int'(log_data[f]), efin);
      chk(log_addr[f+1] == UPD_A && int'(log_data[f+1]) == 1, "R7 final apply write",
          int'(log_addr[f+1]), int'(UPD_A));
    end
    chk(applied == efin, "R9 applied delay", applied, efin);
    chk(cal_pass == ef, "R8 pass flag", int'(cal_pass), int'(ef));
    chk(int'(win_start) == es, "R6 window start", int'(win_start), es);
    chk(int'(win_end) == ee, "R6 window end", int'(win_end), ee);
    chk(int'(win_width) == ew, "R7 window width", int'(win_width), ew);
    chk(int'(win_center) == ec, "R7 window centre", int'(win_center), ec);
    repeat (3) @(negedge clk);
    chk(cal_done && !cal_busy, "R9 done held", int'(cal_done), 1);
  endtask

  initial begin
    #(8 * 190000);
    $display("FAIL R9 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!cal_busy && !cal_done && !cal_pass, "R1 status after reset", int'(cal_busy), 0);
    chk(!reg_write && !reg_read && !test_start, "R1 no requests after reset", int'(reg_write), 0);
    chk(win_center == '0 && win_width == '0, "R1 results zero", int'(win_width), 0);
    // directed corners
    run_case(10, 20, 999, 999, 37, 1, 1);  // R5 stray done, R2 restart ignored
    run_case(200, 200, 999, 999, 41, 0, 0); // R8 nothing passes
    run_case(50, 70, 999, 999, 9, 0, 0);    // R6 window reaches the top
    run_case(0, 8, 999, 999, 22, 0, 0);     // R6 window from the bottom
    run_case(12, 14, 30, 40, 5, 0, 0);      // R6 only the first window kept
    run_case(32, 32, 999, 999, 17, 0, 0);   // R7 single-code window
    // random windows
    for (int k = 0; k < 8; k++) begin
      int a = int'($urandom % 70);
      int b = a + int'($urandom % 20);
      int c = b + 3 + int'($urandom % 20);
      run_case(a, b, c, c + int'($urandom % 10), int'($urandom % 64), k[0], 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule